// File: doc/BRIEF.md
# Tributary Clock-Loss Monitor with Alarm Substitution

This block conditions one DS1 or E1 tributary before it reaches a second-order multiplexer. A free-running reference clock watches the tributary line clock. When the line clock stops, the block raises a loss-of-clock flag. It also replaces the tributary with an unframed all-ones alarm indication signal (AIS). That substitute stream runs on a locally supplied alarm clock, chosen by the line type. When the line clock returns, the output goes back to the retimed line data on the line clock.

The incoming data is captured on the line clock as soon as it arrives. A configuration bit chooses which edge of the line clock does the capture. The output clock moves between the line clock and the alarm clock through a break-before-make handover, so the output clock never carries a shortened pulse. The loss-of-clock status is sticky and is cleared by a one-cycle strobe in the reference domain.

Top module: `trib_mon`

## Requirements
- R1: The loss-of-clock condition is declared when `LOC_LIMIT` (default 32) consecutive reference cycles pass with no line-clock transition seen through a two-flop synchronizer. A pause shorter than that declares nothing.
- R2: The loss-of-clock condition clears on the first line-clock transition seen by the synchronizer after it was declared.
- R3: `loc_status` is 1 whenever the condition is present. Once set, it stays 1 until a `loc_clear` pulse is sampled while the condition is absent. A clear pulse while the condition is still present leaves it at 1.
- R4: While the alarm substitution is active, `out_data` is 1, whatever `line_data` carries.
- R5: During substitution, `out_clk` follows `ds1_ais_clk` when `cfg_ds1` is 1 (DS1 line) and `e1_ais_clk` when `cfg_ds1` is 0 (E1 line).
- R6: With `cfg_rise` = 1, `out_data` is the value of `line_data` captured on the rising edge of `line_clk`. With `cfg_rise` = 0, it is the value captured on the falling edge.
- R7: In normal operation, `out_clk` equals `line_clk`.
- R8: The two clock sources are never enabled at the same time. While neither is enabled, `out_clk` is 0.
- R9: After the line clock returns, the output goes back to the line clock and to the retimed line data.
- R10: During reset, `loc_status` is 0, `out_clk` is 0 and `out_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for the activity monitor |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | Tributary line clock |
| line_data | input | 1 | Tributary line data |
| ds1_ais_clk | input | 1 | Local alarm clock used for DS1 lines |
| e1_ais_clk | input | 1 | Local alarm clock used for E1 lines |
| cfg_ds1 | input | 1 | Line type: 1 = DS1, 0 = E1 (static while in use) |
| cfg_rise | input | 1 | Capture edge: 1 = rising, 0 = falling |
| loc_clear | input | 1 | Write-one-to-clear strobe for the sticky status (reference domain) |
| out_clk | output | 1 | Conditioned tributary clock |
| out_data | output | 1 | Conditioned tributary data |
| loc_status | output | 1 | Sticky loss-of-clock status |

## Verification
The bench goes after the threshold edge of the activity counter. If that count were off by one, or the synchronizer depth differed, the status would rise a cycle early or late, and the per-cycle model comparison would flag it. A pause just short of the limit must leave the status clear. The bench pulses the clear strobe while the loss is still present; a status that cleared unconditionally would then read 0. It also checks that the status is still set after the clock has returned and clears only on a later strobe.

Each capture-edge setting is tested with data that changes between the rising and falling edges, so a swapped edge select shows up as inverted data. During substitution the output clock is sampled against both alarm clocks, which catches a swapped line-type select. It is also sampled against a stopped line clock, which catches an output that stays tied to the line. Finally, the bench brings the line clock back and checks that line data and the line clock reach the output again, which catches a handover that stalls or never releases the alarm side.

// File: rtl/trib_mon_pkg.sv
package trib_mon_pkg;

    typedef enum logic {
        KIND_E1  = 1'b0,
        KIND_DS1 = 1'b1
    } line_kind_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/trib_loc_watch.sv
// Reference-domain activity monitor: synchronizes the line clock, counts
// quiet reference cycles, and keeps a live and a sticky loss flag.
module trib_loc_watch #(
    parameter int LOC_LIMIT   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic clear_i,
    output logic loc_o,
    output logic sticky_o
);

    localparam int CNT_W = $clog2(LOC_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(LOC_LIMIT);
    localparam logic [CNT_W-1:0] LIM_LAST = CNT_W'(LOC_LIMIT - 1);

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        logic [CNT_W-1:0]     cnt;
        logic                 loc;
        logic                 sticky;
    } watch_t;

    watch_t st_d, st_q;
    logic   trans;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SYNC_STAGES-1:0], line_clk};
        trans   = st_q.sh[SYNC_STAGES-1] ^ st_q.sh[SYNC_STAGES];
        if (trans) begin
            st_d.cnt = '0;
            st_d.loc = 1'b0;
        end else begin
            if (st_q.cnt != LIM_FULL) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt == LIM_LAST) begin
                st_d.loc = 1'b1;
            end
        end
        st_d.sticky = st_d.loc | (st_q.sticky & ~clear_i);
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loc_o    = st_q.loc;
    assign sticky_o = st_q.sticky;

    // R1: the flag only appears after the quiet count reached its last step
    p_no_early_loc_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(st_q.loc) |-> $past(st_q.cnt) == LIM_LAST);

    // R2: an observed transition always removes the live condition
    p_loc_drops_on_edge_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.loc && trans) |=> !st_q.loc);

    // R3: live condition implies sticky status
    p_status_covers_loc_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        st_q.loc |-> st_q.sticky);

    // R3: sticky status holds without a clear strobe
    p_status_holds_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.sticky && !clear_i) |=> st_q.sticky);

endmodule

// File: rtl/trib_retime.sv
// Captures line data on both edges of the line clock and selects one.
module trib_retime (
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_data,
    input  logic rise_sel,
    output logic data_o
);

    import trib_mon_pkg::*;

    logic rise_d, rise_q;
    logic fall_d, fall_q;

    always_comb begin
        rise_d = line_data;
        fall_d = line_data;
    end

    always_ff @(posedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= 1'b1;
        end else begin
            rise_q <= rise_d;
        end
    end

    always_ff @(negedge line_clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= 1'b1;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign data_o = (edge_sel_e'(rise_sel) == EDGE_RISE) ? rise_q : fall_q;

endmodule

// File: rtl/trib_clk_handover.sv
// Break-before-make handover between the line clock and the alarm clock.
// Each side enables itself on its own falling edge, only after the other
// side has released. The line side is cleared at once when the loss
// condition appears, because a stopped clock cannot step its own chain.
module trib_clk_handover #(
    parameter int HAND_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic ais_clk,
    input  logic loc_i,
    output logic line_en_o,
    output logic ais_en_o
);

    logic [HAND_STAGES-1:0] line_d, line_q;
    logic [HAND_STAGES-1:0] ais_d, ais_q;
    logic                   line_clr;

    assign line_clr  = !rst_n || loc_i;
    assign line_en_o = line_q[HAND_STAGES-1];
    assign ais_en_o  = ais_q[HAND_STAGES-1];

    always_comb begin
        line_d = {line_q[HAND_STAGES-2:0], ~ais_en_o};
        ais_d  = {ais_q[HAND_STAGES-2:0], loc_i & ~line_en_o};
    end

    always_ff @(negedge line_clk or posedge line_clr) begin
        if (line_clr) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    always_ff @(negedge ais_clk or negedge rst_n) begin
        if (!rst_n) begin
            ais_q <= '0;
        end else begin
            ais_q <= ais_d;
        end
    end

    // R8: never both sources at once
    p_break_before_make_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $onehot0({line_en_o, ais_en_o}));

    // R4: a settled loss condition keeps the line source off
    p_line_off_in_loss_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        loc_i |-> !line_en_o);

endmodule

// File: rtl/trib_mon.sv
module trib_mon #(
    parameter int LOC_LIMIT   = 32,
    parameter int SYNC_STAGES = 2,
    parameter int HAND_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic line_clk,
    input  logic line_data,
    input  logic ds1_ais_clk,
    input  logic e1_ais_clk,
    input  logic cfg_ds1,
    input  logic cfg_rise,
    input  logic loc_clear,
    output logic out_clk,
    output logic out_data,
    output logic loc_status
);

    import trib_mon_pkg::*;

    logic loc_live;
    logic line_en;
    logic ais_en;
    logic ais_clk;
    logic retimed;

    assign ais_clk = (line_kind_e'(cfg_ds1) == KIND_DS1) ? ds1_ais_clk : e1_ais_clk;

    trib_loc_watch #(
        .LOC_LIMIT   (LOC_LIMIT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_watch (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .line_clk (line_clk),
        .clear_i  (loc_clear),
        .loc_o    (loc_live),
        .sticky_o (loc_status)
    );

    trib_retime u_retime (
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .line_data (line_data),
        .rise_sel  (cfg_rise),
        .data_o    (retimed)
    );

    trib_clk_handover #(
        .HAND_STAGES (HAND_STAGES)
    ) u_hand (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .line_clk  (line_clk),
        .ais_clk   (ais_clk),
        .loc_i     (loc_live),
        .line_en_o (line_en),
        .ais_en_o  (ais_en)
    );

    assign out_clk  = (line_clk & line_en) | (ais_clk & ais_en);
    assign out_data = line_en ? retimed : 1'b1;

    // R4: alarm source enabled means all-ones data
    p_ais_ones_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ais_en |-> out_data);

    // R8: no source enabled means a quiet output clock
    p_gap_quiet_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!line_en && !ais_en) |-> !out_clk);

endmodule

// File: tb/trib_mon_bench.sv
module trib_mon_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 32;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic line_clk = 1'b0;
    logic line_data = 1'b0;
    logic ds1_ais_clk = 1'b0;
    logic e1_ais_clk = 1'b0;
    logic cfg_ds1 = 1'b1;
    logic cfg_rise = 1'b1;
    logic loc_clear = 1'b0;
    logic out_clk, out_data, loc_status;
    logic line_run = 1'b1;
    bit   done = 1'b0;

    int checks = 0;
    int fails  = 0;

    trib_mon u_trib_mon (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .line_clk    (line_clk),
        .line_data   (line_data),
        .ds1_ais_clk (ds1_ais_clk),
        .e1_ais_clk  (e1_ais_clk),
        .cfg_ds1     (cfg_ds1),
        .cfg_rise    (cfg_rise),
        .loc_clear   (loc_clear),
        .out_clk     (out_clk),
        .out_data    (out_data),
        .loc_status  (loc_status)
    );

    initial forever #(CLK_PERIOD / 2) ref_clk = ~ref_clk;

    initial begin
        #3;
        forever begin
            if (line_run) line_clk = ~line_clk;
            #20;
        end
    end

    initial begin
        #1;
        forever begin
            ds1_ais_clk = ~ds1_ais_clk;
            #12;
        end
    end

    initial begin
        #4;
        forever begin
            e1_ais_clk = ~e1_ais_clk;
            #8;
        end
    end

    // Behavioural reference for the status: sample history plus counters.
    logic samples[$] = '{1'b0, 1'b0, 1'b0, 1'b0};
    int   m_quiet  = 0;
    bit   m_loc    = 1'b0;
    bit   m_sticky = 1'b0;

    always @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            samples  = '{1'b0, 1'b0, 1'b0, 1'b0};
            m_quiet  = 0;
            m_loc    = 1'b0;
            m_sticky = 1'b0;
        end else begin
            samples.push_front(line_clk);
            void'(samples.pop_back());
            if (samples[2] != samples[3]) begin
                m_quiet = 0;
                m_loc   = 1'b0;
            end else begin
                if (m_quiet == LIMIT - 1) m_loc = 1'b1;
                if (m_quiet < LIMIT) m_quiet++;
            end
            m_sticky = m_loc | (m_sticky & ~loc_clear);
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge ref_clk) begin
        if (rst_n && !done) chk(loc_status, m_sticky, "R1/R2/R3 loc_status vs model");
    end

    task automatic pulse_clear();
        @(negedge ref_clk);
        loc_clear = 1'b1;
        @(negedge ref_clk);
        loc_clear = 1'b0;
    endtask

    // R6/R7: data changes between the edges, so each edge choice sees a different bit
    task automatic check_edge(input logic rise, input logic a, input logic b, input string tag);
        cfg_rise = rise;
        @(negedge line_clk);
        #5 line_data = a;
        @(posedge line_clk);
        #5 line_data = b;
        chk(out_clk, 1'b1, {tag, " R7 out_clk high"});
        @(negedge line_clk);
        #5;
        chk(out_clk, 1'b0, {tag, " R7 out_clk low"});
        chk(out_data, rise ? a : b, {tag, " R6 captured data"});
    endtask

    task automatic check_ais(input bit ds1);
        for (int i = 0; i < 3; i++) begin
            if (ds1) begin
                @(posedge ds1_ais_clk); #2;
                chk(out_clk, 1'b1, "R5 follows ds1 alarm clock high");
                chk(out_data, 1'b1, "R4 all-ones data");
                @(negedge ds1_ais_clk); #2;
                chk(out_clk, 1'b0, "R5 follows ds1 alarm clock low");
                @(posedge e1_ais_clk); #2;
                chk(out_clk, ds1_ais_clk, "R5 ignores e1 alarm clock");
            end else begin
                @(posedge e1_ais_clk); #2;
                chk(out_clk, 1'b1, "R5 follows e1 alarm clock high");
                chk(out_data, 1'b1, "R4 all-ones data");
                @(negedge e1_ais_clk); #2;
                chk(out_clk, 1'b0, "R5 follows e1 alarm clock low");
                @(posedge ds1_ais_clk); #2;
                chk(out_clk, e1_ais_clk, "R5 ignores ds1 alarm clock");
            end
        end
    endtask

    initial begin
        #42;
        chk(loc_status, 1'b0, "R10 reset loc_status");
        chk(out_clk, 1'b0, "R10 reset out_clk");
        chk(out_data, 1'b1, "R10 reset out_data");
        #10 rst_n = 1'b1;
        #300;

        check_edge(1'b1, 1'b1, 1'b0, "rise 1/0");
        check_edge(1'b1, 1'b0, 1'b1, "rise 0/1");
        check_edge(1'b0, 1'b1, 1'b0, "fall 1/0");
        check_edge(1'b0, 1'b0, 1'b1, "fall 0/1");
        chk(loc_status, 1'b0, "R1 no loss while running");

        // DS1 loss episode
        line_run  = 1'b0;
        line_data = 1'b0;
        #700;
        chk(loc_status, 1'b1, "R1 loss declared");
        check_ais(1'b1);
        pulse_clear();
        #1 chk(loc_status, 1'b1, "R3 clear ignored while loss present");
        line_run = 1'b1;
        #500;
        chk(loc_status, 1'b1, "R3 status sticky after return");
        pulse_clear();
        @(negedge ref_clk);
        #1 chk(loc_status, 1'b0, "R3 status cleared after return");
        check_edge(1'b1, 1'b1, 1'b0, "R9 back to line");
        check_edge(1'b0, 1'b0, 1'b1, "R9 back to line");

        // Short pause: below the limit, nothing declared
        line_run = 1'b0;
        #200;
        line_run = 1'b1;
        #100;
        chk(loc_status, 1'b0, "R1 short pause not declared");

        // E1 loss episode
        cfg_ds1  = 1'b0;
        line_run = 1'b0;
        line_data = 1'b0;
        #700;
        chk(loc_status, 1'b1, "R1 loss declared e1");
        check_ais(1'b0);
        line_run = 1'b1;
        #500;
        pulse_clear();
        @(negedge ref_clk);
        #1 chk(loc_status, 1'b0, "R2 condition gone after return");
        check_edge(1'b0, 1'b0, 1'b1, "R9 back to line e1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired, run hung");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule